// File: doc/BRIEF.md
# Bidirectional Panel Scan Driver Model

This block is a synthesizable behavioural model of the scanning logic inside a small active-matrix colour display. It is placed next to a timing generator and checks it. It observes the same strobes the panel would receive and reports which horizontal sampling stage and which gate line the panel would select at each moment. All inputs are sampled on one system clock, and the model reacts to the edges it sees in those samples.

Horizontally, a token enters on a rising edge of the first horizontal phase clock while the start pulse is high. It then moves one stage on each later rising edge of that phase. Each stage stands for one simultaneous red, green and blue sample, so a full row of 800 electrodes takes 267 stages. A direction input picks left-to-right or right-to-left order. Vertically, a second token enters on any edge of the vertical clock while the vertical start pulse is high. It moves one gate line per edge, rising or falling, down 225 lines, and it is shown as selected only while the enable input is high. The model also flags a start pulse that lands on a row still in progress and overlapping horizontal phases, and it reports how many stages each row used.

Top module: `scan_driver`

## Requirements
- R1: After reset, stageValid, gateValid, lineEnd, lineBad, startErr and phaseErr are all 0.
- R2: A rising edge of hck1 (present sample 1, previous sample 0) with hst high loads the horizontal token. One clock later stageValid is 1 and stageIdx is 0 if scanRight is 1, or H_STAGES-1 if scanRight is 0.
- R3: Each later hck1 rising edge with hst low moves stageIdx by +1 (scanRight was 1 at load) or by -1 (scanRight was 0 at load). A change of scanRight after the load has no effect on the order.
- R4: The hck1 rising edge after the last stage drops the token. For exactly one clock, stageValid goes to 0, lineEnd is 1, lineCount equals H_STAGES and lineBad is 0. After that, further hck1 edges without hst change nothing.
- R5: An hck1 rising edge with hst high while a token is active pulses startErr and lineEnd for one clock. lineCount then shows the stages sampled so far and lineBad is 1, and the token restarts at the first stage.
- R6: phaseErr is 1 in the clock after hck1 and hck2 are both sampled high, and 0 otherwise.
- R7: Any vck edge with vst high selects gate line 0. Each later vck edge, rising or falling, with vst low moves to the next line. The edge after line V_LINES-1 deselects, and further edges without vst keep it deselected.
- R8: gateValid is 1 only while a gate line is selected and en is high. Holding en low hides the line but does not stop the vertical scan.
- R9: Edges of hck2 alone never move the horizontal token.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Active-low reset |
| hck1 | input | 1 | First horizontal phase clock; its rising edge captures and moves the token |
| hck2 | input | 1 | Second horizontal phase clock (complement) |
| hst | input | 1 | Horizontal start pulse |
| scanRight | input | 1 | 1 = left-to-right order, 0 = right-to-left |
| vck | input | 1 | Vertical clock; both edges advance |
| vst | input | 1 | Vertical start pulse |
| en | input | 1 | Gate enable |
| stageIdx | output | clog2(H_STAGES) | Active sampling stage |
| stageValid | output | 1 | A stage is being sampled |
| lineEnd | output | 1 | One-clock pulse when a row finishes or is cut short |
| lineCount | output | clog2(H_STAGES+1) | Stages sampled in the row just ended |
| lineBad | output | 1 | Row ended with a count other than H_STAGES |
| startErr | output | 1 | Start pulse arrived during an active row |
| phaseErr | output | 1 | Both horizontal phases were high together |
| gateIdx | output | clog2(V_LINES) | Selected gate line |
| gateValid | output | 1 | Gate line selected and enabled |

## Verification
The bench builds the block with H_STAGES = 6 and V_LINES = 4. With these values, both ends of the horizontal scan in each direction, the token falling off after the last stage, and the vertical token leaving the bottom line can all be reached in a few dozen phase pairs. The same values let a row cut short by a second start pulse give a count that is clearly different from the full count.

// File: rtl/scan_driver_pkg.sv
package scan_driver_pkg;
  // Strobes from edge detection to the scan registers.
  typedef struct packed {
    logic hLoad;   // hck1 rise with start pulse
    logic hStep;   // hck1 rise without start pulse
    logic vLoad;   // vck edge with vertical start
    logic vStep;   // vck edge without vertical start
    logic clash;   // both horizontal phases high
  } scanStrobe_t;
endpackage

// File: rtl/scan_driver_ctrl.sv
module scan_driver_ctrl
  import scan_driver_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        hck1,
  input  logic        hck2,
  input  logic        hst,
  input  logic        vck,
  input  logic        vst,
  output scanStrobe_t strobe
);
  logic hck1Q;
  logic vckQ;
  logic hEdge;
  logic vEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hck1Q <= 1'b0;
      vckQ  <= 1'b0;
    end else begin
      hck1Q <= hck1;
      vckQ  <= vck;
    end
  end

  always_comb begin
    hEdge        = hck1 & ~hck1Q;
    vEdge        = vck ^ vckQ;
    strobe.hLoad = hEdge & hst;
    strobe.hStep = hEdge & ~hst;
    strobe.vLoad = vEdge & vst;
    strobe.vStep = vEdge & ~vst;
    strobe.clash = hck1 & hck2;
  end
endmodule

// File: rtl/scan_driver_datapath.sv
module scan_driver_datapath
  import scan_driver_pkg::*;
#(
  parameter int H_STAGES = 267,
  parameter int V_LINES  = 225
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  scanStrobe_t                   strobe,
  input  logic                          scanRight,
  input  logic                          en,
  output logic [$clog2(H_STAGES)-1:0]   stageIdx,
  output logic                          stageValid,
  output logic                          lineEnd,
  output logic [$clog2(H_STAGES+1)-1:0] lineCount,
  output logic                          lineBad,
  output logic                          startErr,
  output logic                          phaseErr,
  output logic [$clog2(V_LINES)-1:0]    gateIdx,
  output logic                          gateValid
);
  localparam int HW = $clog2(H_STAGES);
  localparam int CW = $clog2(H_STAGES + 1);
  localparam int VW = $clog2(V_LINES);
  localparam logic [HW-1:0] H_LAST = HW'(H_STAGES - 1);
  localparam logic [CW-1:0] H_FULL = CW'(H_STAGES);
  localparam logic [VW-1:0] V_LAST = VW'(V_LINES - 1);

  logic          hActive;
  logic          hDirRight;
  logic [HW-1:0] hIdx;
  logic [CW-1:0] hCount;
  logic          hAtEnd;
  logic          vActive;
  logic [VW-1:0] vIdx;

  assign hAtEnd = hDirRight ? (hIdx == H_LAST) : (hIdx == '0);

  // Horizontal token, row accounting and error pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hActive   <= 1'b0;
      hDirRight <= 1'b1;
      hIdx      <= '0;
      hCount    <= '0;
      lineEnd   <= 1'b0;
      lineCount <= '0;
      lineBad   <= 1'b0;
      startErr  <= 1'b0;
      phaseErr  <= 1'b0;
    end else begin
      lineEnd  <= 1'b0;
      startErr <= 1'b0;
      phaseErr <= strobe.clash;
      if (strobe.hLoad) begin
        if (hActive) begin
          startErr  <= 1'b1;
          lineEnd   <= 1'b1;
          lineCount <= hCount;
          lineBad   <= (hCount != H_FULL);
        end
        hActive   <= 1'b1;
        hDirRight <= scanRight;
        hIdx      <= scanRight ? '0 : H_LAST;
        hCount    <= CW'(1);
      end else if (strobe.hStep && hActive) begin
        if (hAtEnd) begin
          hActive   <= 1'b0;
          lineEnd   <= 1'b1;
          lineCount <= hCount;
          lineBad   <= (hCount != H_FULL);
        end else begin
          hIdx   <= hDirRight ? hIdx + 1'b1 : hIdx - 1'b1;
          hCount <= hCount + 1'b1;
        end
      end
    end
  end

  // Vertical token
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vActive <= 1'b0;
      vIdx    <= '0;
    end else if (strobe.vLoad) begin
      vActive <= 1'b1;
      vIdx    <= '0;
    end else if (strobe.vStep && vActive) begin
      if (vIdx == V_LAST) begin
        vActive <= 1'b0;
        vIdx    <= '0;
      end else begin
        vIdx <= vIdx + 1'b1;
      end
    end
  end

  assign stageValid = hActive;
  assign stageIdx   = hActive ? hIdx : '0;
  assign gateValid  = vActive & en;
  assign gateIdx    = vActive ? vIdx : '0;
endmodule

// File: rtl/scan_driver.sv
module scan_driver
  import scan_driver_pkg::*;
#(
  parameter int H_STAGES = 267,
  parameter int V_LINES  = 225
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          hck1,
  input  logic                          hck2,
  input  logic                          hst,
  input  logic                          scanRight,
  input  logic                          vck,
  input  logic                          vst,
  input  logic                          en,
  output logic [$clog2(H_STAGES)-1:0]   stageIdx,
  output logic                          stageValid,
  output logic                          lineEnd,
  output logic [$clog2(H_STAGES+1)-1:0] lineCount,
  output logic                          lineBad,
  output logic                          startErr,
  output logic                          phaseErr,
  output logic [$clog2(V_LINES)-1:0]    gateIdx,
  output logic                          gateValid
);
  scanStrobe_t strobe;

  scan_driver_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .hck1   (hck1),
    .hck2   (hck2),
    .hst    (hst),
    .vck    (vck),
    .vst    (vst),
    .strobe (strobe)
  );

  scan_driver_datapath #(
    .H_STAGES (H_STAGES),
    .V_LINES  (V_LINES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .scanRight  (scanRight),
    .en         (en),
    .stageIdx   (stageIdx),
    .stageValid (stageValid),
    .lineEnd    (lineEnd),
    .lineCount  (lineCount),
    .lineBad    (lineBad),
    .startErr   (startErr),
    .phaseErr   (phaseErr),
    .gateIdx    (gateIdx),
    .gateValid  (gateValid)
  );
endmodule

// File: rtl/scan_driver_chk.sv
module scan_driver_chk #(
  parameter int H_STAGES = 267,
  parameter int V_LINES  = 225
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          hck1,
  input logic                          hck2,
  input logic                          en,
  input logic [$clog2(H_STAGES)-1:0]   stageIdx,
  input logic                          stageValid,
  input logic                          lineEnd,
  input logic                          lineBad,
  input logic                          startErr,
  input logic                          phaseErr,
  input logic [$clog2(V_LINES)-1:0]    gateIdx,
  input logic                          gateValid
);
  // R2
  stage_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    stageValid |-> int'(stageIdx) < H_STAGES);

  // R3
  stage_single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stageValid && $past(stageValid) && !startErr) |->
      (int'(stageIdx) == int'($past(stageIdx)) ||
       int'(stageIdx) == int'($past(stageIdx)) + 1 ||
       int'(stageIdx) + 1 == int'($past(stageIdx))));

  // R4
  full_row_clean_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineEnd && !startErr) |-> !lineBad);

  // R5
  overlap_ends_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    startErr |-> (lineEnd && stageValid));

  // R6
  phase_clash_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseErr |-> $past(hck1 && hck2));

  // R7
  gate_in_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateValid |-> int'(gateIdx) < V_LINES);

  // R8
  gate_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    gateValid |-> en);
endmodule

bind scan_driver scan_driver_chk #(
  .H_STAGES (H_STAGES),
  .V_LINES  (V_LINES)
) u_chk (.*);

// File: tb/scan_driver_tb.sv
module scan_driver_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H_ST = 6;
  localparam int V_LN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hck1 = 1'b0, hck2 = 1'b0, hst = 1'b0, scanRight = 1'b1;
  logic vck = 1'b0, vst = 1'b0, en = 1'b1;
  logic [$clog2(H_ST)-1:0]   stageIdx;
  logic                      stageValid, lineEnd, lineBad, startErr, phaseErr;
  logic [$clog2(H_ST+1)-1:0] lineCount;
  logic [$clog2(V_LN)-1:0]   gateIdx;
  logic                      gateValid;

  int nChecks = 0;
  int nFails  = 0;
  // values captured in the clock right after an hck1 rise
  int seenEnd, seenCount, seenBad, seenStartErr;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_driver #(.H_STAGES(H_ST), .V_LINES(V_LN)) u_dut (
    .clk(clk), .rstN(rstN), .hck1(hck1), .hck2(hck2), .hst(hst),
    .scanRight(scanRight), .vck(vck), .vst(vst), .en(en),
    .stageIdx(stageIdx), .stageValid(stageValid), .lineEnd(lineEnd),
    .lineCount(lineCount), .lineBad(lineBad), .startErr(startErr),
    .phaseErr(phaseErr), .gateIdx(gateIdx), .gateValid(gateValid)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One phase pair; the start pulse is presented with the hck1 rise.
  task automatic hPair(input logic startVal);
    @(negedge clk); hck1 = 1'b1; hst = startVal;
    @(negedge clk); hck1 = 1'b0; hst = 1'b0;
    seenEnd = int'(lineEnd); seenCount = int'(lineCount);
    seenBad = int'(lineBad); seenStartErr = int'(startErr);
    @(negedge clk); hck2 = 1'b1;
    @(negedge clk); hck2 = 1'b0;
    @(negedge clk);
  endtask

  task automatic vEdge(input logic startVal);
    @(negedge clk); vck = ~vck; vst = startVal;
    @(negedge clk); vst = 1'b0;
  endtask

  task automatic testReset();
    check("R1 stageValid", int'(stageValid), 0);
    check("R1 gateValid", int'(gateValid), 0);
    check("R1 lineEnd", int'(lineEnd), 0);
    check("R1 lineBad", int'(lineBad), 0);
    check("R1 startErr", int'(startErr), 0);
    check("R1 phaseErr", int'(phaseErr), 0);
  endtask

  task automatic testRightScan();
    scanRight = 1'b1;
    hPair(1'b1);
    check("R2 load valid", int'(stageValid), 1);
    check("R2 load right idx", int'(stageIdx), 0);
    for (int k = 1; k < H_ST; k++) begin
      hPair(1'b0);
      check("R3 right step", int'(stageIdx), k);
    end
    hPair(1'b0);
    check("R4 token dropped", int'(stageValid), 0);
    check("R4 lineEnd pulse", seenEnd, 1);
    check("R4 lineCount full", seenCount, H_ST);
    check("R4 lineBad clear", seenBad, 0);
    check("R4 lineEnd one clock", int'(lineEnd), 0);
    hPair(1'b0);
    check("R4 idle ignores hck1", int'(stageValid), 0);
    check("R4 idle no lineEnd", seenEnd, 0);
  endtask

  task automatic testLeftScan();
    scanRight = 1'b0;
    hPair(1'b1);
    check("R2 load left idx", int'(stageIdx), H_ST - 1);
    hPair(1'b0);
    check("R3 left step", int'(stageIdx), H_ST - 2);
    scanRight = 1'b1;  // must not change order of this row
    hPair(1'b0);
    check("R3 direction latched", int'(stageIdx), H_ST - 3);
    for (int k = H_ST - 4; k >= 0; k--) hPair(1'b0);
    check("R3 left reaches 0", int'(stageIdx), 0);
    hPair(1'b0);
    check("R4 left drop", int'(stageValid), 0);
    check("R4 left count", seenCount, H_ST);
  endtask

  task automatic testOverlap();
    scanRight = 1'b1;
    hPair(1'b1);
    hPair(1'b0);
    hPair(1'b0);
    hPair(1'b1);
    check("R5 startErr", seenStartErr, 1);
    check("R5 lineEnd", seenEnd, 1);
    check("R5 short count", seenCount, 3);
    check("R5 lineBad", seenBad, 1);
    check("R5 restart idx", int'(stageIdx), 0);
    check("R5 restart valid", int'(stageValid), 1);
    check("R5 startErr one clock", int'(startErr), 0);
    // R9: hck2 alone leaves the token in place
    @(negedge clk); hck2 = 1'b1;
    @(negedge clk); hck2 = 1'b0;
    @(negedge clk);
    check("R9 hck2 no move", int'(stageIdx), 0);
    for (int k = 1; k <= H_ST; k++) hPair(1'b0);
    check("R5 next row clean", seenBad, 0);
    check("R5 next row count", seenCount, H_ST);
  endtask

  task automatic testPhaseClash();
    @(negedge clk); hck1 = 1'b1; hck2 = 1'b1;
    @(negedge clk);
    check("R6 clash flagged", int'(phaseErr), 1);
    hck1 = 1'b0; hck2 = 1'b0;
    @(negedge clk);
    check("R6 clash cleared", int'(phaseErr), 0);
    hck1 = 1'b1;
    @(negedge clk);
    check("R6 single phase clean", int'(phaseErr), 0);
    hck1 = 1'b0;
    @(negedge clk);
  endtask

  task automatic testVertical();
    en = 1'b1;
    vEdge(1'b1);
    check("R7 load valid", int'(gateValid), 1);
    check("R7 load line 0", int'(gateIdx), 0);
    for (int k = 1; k < V_LN; k++) begin
      vEdge(1'b0);
      check("R7 both-edge step", int'(gateIdx), k);
    end
    vEdge(1'b0);
    check("R7 off bottom", int'(gateValid), 0);
    vEdge(1'b0);
    check("R7 stays off", int'(gateValid), 0);
  endtask

  task automatic testEnable();
    vEdge(1'b1);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R8 en low hides", int'(gateValid), 0);
    vEdge(1'b0);
    check("R8 hidden while scanning", int'(gateValid), 0);
    en = 1'b1;
    @(negedge clk);
    check("R8 en high shows", int'(gateValid), 1);
    check("R8 scan continued", int'(gateIdx), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRightScan();
    testLeftScan();
    testOverlap();
    testPhaseClash();
    testVertical();
    testEnable();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule